// File: doc/BRIEF.md
# Chained Multi-Word Compare Flag Unit

This block computes the condition flags of a compare operation. It subtracts one operand word from the other, keeps none of the difference, and loads negative (N), zero (Z), carry (C) and overflow (V) into a small status register. A second operation, compare-with-carry, also subtracts the borrow left by the previous word. Both operations read the status register that the block holds itself.

To compare operands wider than one word, software issues a plain compare on the least significant word. It then issues one compare-with-carry for each higher word, ending on the most significant one. Compare-with-carry ANDs its own zero result into the stored Z. After the last word, Z is therefore true only when every word matched. C, N and V come from the last word and describe the whole wide compare, so any signed or unsigned condition can be derived from the four flags.

The block has no data stream. Operands and the operation select are sampled on the clock edge when `en` is high, and the flags appear one cycle later. Carry follows the no-borrow convention: C=1 means the first operand is higher than or equal to the second, unsigned.

Top module: `cmp_flags_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears N, Z, C and V to 0 at that edge, whatever `en` is.
- R2: While `en` is low, all four flags keep their values, even when the operands and the operation select change.
- R3: With `op_carry`=0 (plain compare), C after the edge is 1 exactly when `opa` >= `opb` as unsigned numbers. The stored C has no effect.
- R4: With `op_carry`=0, Z after the edge is 1 exactly when `opa` equals `opb`. The stored Z has no effect.
- R5: N after the edge equals the most significant bit of the word difference.
- R6: V after the edge is 1 exactly when `opa` and `opb` have different sign bits and the sign of the difference differs from the sign of `opa`.
- R7: With `op_carry`=1, the word difference is `opa` - `opb` - (1 - stored C) modulo 2^WORD_W. C after the edge is 1 exactly when that subtraction needs no borrow.
- R8: With `op_carry`=1, Z after the edge is the stored Z ANDed with (word difference == 0). A chain that has once cleared Z keeps it clear.
- R9: A plain compare on the low word, followed by compare-with-carry on each higher word in ascending order, leaves N, Z, C and V equal to the flags of a single compare of the full-width operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Load the new flags on this edge |
| op_carry | input | 1 | 0 = plain compare, 1 = compare-with-carry |
| opa | input | WORD_W | First operand (minuend) |
| opb | input | WORD_W | Second operand (subtrahend) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag, 1 = no borrow |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The bench builds the unit with WORD_W=8 and SLICE_W=4. An 8-bit word makes the sign and boundary values (0x00, 0x7F, 0x80, 0xFF) short to write. Two- and three-word chains then stand for 16- and 24-bit compares whose flags can be worked out by hand. The two 4-bit adder slices mean that every borrow crossing the middle of a word passes through the carry link between slices. That link is exercised by the rows where a low-word borrow ripples through a high word of all ones or all zeros.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cmp_flags_t;

  typedef enum logic {
    OP_CMP  = 1'b0,
    OP_CMPC = 1'b1
  } cmp_op_e;

endpackage

// File: rtl/cmpf_sub.sv
// Sliced subtractor: a + ~b + cin, rippled through SLICE_W-bit groups.
module cmpf_sub #(
  parameter int WORD_W  = 16,
  parameter int SLICE_W = 4
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              cin,
  output logic [WORD_W-1:0] diff,
  output logic              cout
);
  localparam int NSL = WORD_W / SLICE_W;

  logic [NSL:0] cy;

  assign cy[0] = cin;

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    logic [SLICE_W-1:0] a_s, nb_s, d_s;
    logic               co_s;
    assign a_s  = a[s*SLICE_W +: SLICE_W];
    assign nb_s = ~b[s*SLICE_W +: SLICE_W];
    assign {co_s, d_s} = {1'b0, a_s} + {1'b0, nb_s} + {{SLICE_W{1'b0}}, cy[s]};
    assign diff[s*SLICE_W +: SLICE_W] = d_s;
    assign cy[s+1] = co_s;
  end

  assign cout = cy[NSL];
endmodule

// File: rtl/cmpf_flag_form.sv
// Forms the next flag set from the word difference and the stored flags.
module cmpf_flag_form
  import cmpf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  cmp_op_e           op,
  input  cmp_flags_t        cur,
  input  logic              a_msb,
  input  logic              b_msb,
  input  logic [WORD_W-1:0] diff,
  input  logic              no_borrow,
  output cmp_flags_t        nxt
);
  logic word_zero;

  assign word_zero = (diff == '0);

  always_comb begin
    nxt.n = diff[WORD_W-1];
    nxt.c = no_borrow;
    nxt.v = (a_msb ^ b_msb) & (diff[WORD_W-1] ^ a_msb);
    if (op == OP_CMPC) nxt.z = cur.z & word_zero;
    else               nxt.z = word_zero;
  end
endmodule

// File: rtl/cmpf_status_reg.sv
module cmpf_status_reg
  import cmpf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  cmp_flags_t d,
  output cmp_flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/cmp_flags_unit.sv
// Compare / compare-with-carry flag unit with its own status register.
// WORD_W must be a multiple of SLICE_W.
module cmp_flags_unit
  import cmpf_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SLICE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              op_carry,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  cmp_op_e           op;
  cmp_flags_t        cur, nxt;
  logic              sub_cin, sub_cout;
  logic [WORD_W-1:0] diff;

  assign op = cmp_op_e'(op_carry);
  // Carry in of a + ~b: 1 for a plain compare, stored C (no borrow) in a chain.
  assign sub_cin = (op == OP_CMPC) ? cur.c : 1'b1;

  cmpf_sub #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_sub (
    .a(opa), .b(opb), .cin(sub_cin), .diff(diff), .cout(sub_cout)
  );

  cmpf_flag_form #(.WORD_W(WORD_W)) u_form (
    .op(op), .cur(cur), .a_msb(opa[WORD_W-1]), .b_msb(opb[WORD_W-1]),
    .diff(diff), .no_borrow(sub_cout), .nxt(nxt)
  );

  cmpf_status_reg u_sr (
    .clk(clk), .rst(rst), .en(en), .d(nxt), .q(cur)
  );

  assign flag_n = cur.n;
  assign flag_z = cur.z;
  assign flag_c = cur.c;
  assign flag_v = cur.v;
endmodule

// File: rtl/cmp_flags_unit_chk.sv
module cmp_flags_unit_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              op_carry,
  input logic [WORD_W-1:0] opa,
  input logic [WORD_W-1:0] opb,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> {flag_n, flag_z, flag_c, flag_v} == 4'b0000);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  a_r3_cmp_carry: assert property (@(posedge clk) disable iff (rst)
    (en && !op_carry) |=> flag_c == ($past(opa) >= $past(opb)));

  a_r4_cmp_zero: assert property (@(posedge clk) disable iff (rst)
    (en && !op_carry) |=> flag_z == ($past(opa) == $past(opb)));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (en && (opa[WORD_W-1] == opb[WORD_W-1])) |=> !flag_v);

  a_r8_zero_sticks: assert property (@(posedge clk) disable iff (rst)
    (en && op_carry && !flag_z) |=> !flag_z);
endmodule

bind cmp_flags_unit cmp_flags_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .op_carry(op_carry), .opa(opa), .opb(opb),
  .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/tb_cmp_flags_unit.sv
module tb_cmp_flags_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         op_carry = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic         flag_n, flag_z, flag_c, flag_v;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cmp_flags_unit #(.WORD_W(W), .SLICE_W(4)) dut (
    .clk(clk), .rst(rst), .en(en), .op_carry(op_carry), .opa(opa), .opb(opb),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // {A[15:0], B[15:0], expected NZCV} for a two-word chain
  localparam logic [35:0] VEC [0:7] = '{
    {16'h1234, 16'h1234, 4'b0110},
    {16'h1200, 16'h1234, 4'b1000},
    {16'h0100, 16'h00FF, 4'b0010},
    {16'h8000, 16'h0001, 4'b0011},
    {16'h7FFF, 16'hFFFF, 4'b1001},
    {16'hFFFF, 16'h0000, 4'b1010},
    {16'h0000, 16'h0001, 4'b1000},
    {16'hABCD, 16'hABCC, 4'b0010}
  };

  // Called at a falling edge; returns at the next falling edge with flags loaded.
  task automatic step(input logic oc, input logic [W-1:0] a, input logic [W-1:0] b);
    en = 1'b1; op_carry = oc; opa = a; opb = b;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    tests++;
    if ({flag_n, flag_z, flag_c, flag_v} !== exp) begin
      fails++;
      $display("FAIL %s: NZCV actual %b expected %b", req, {flag_n, flag_z, flag_c, flag_v}, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 after reset", 4'b0000);

    // R9 table walk, also covering R5 and R6 values
    for (int i = 0; i < 8; i++) begin
      step(1'b0, VEC[i][27:20], VEC[i][11:4]);
      step(1'b1, VEC[i][35:28], VEC[i][19:12]);
      check($sformatf("R5 R6 R9 row %0d", i), VEC[i][3:0]);
    end

    // R9 three-word chains
    step(1'b0, 8'h00, 8'hFF); step(1'b1, 8'h00, 8'hFF); step(1'b1, 8'h01, 8'h00);
    check("R9 24-bit 010000 vs 00FFFF", 4'b0010);
    step(1'b0, 8'h56, 8'h56); step(1'b1, 8'h34, 8'h34); step(1'b1, 8'h12, 8'h12);
    check("R9 24-bit equal", 4'b0110);

    // R3: plain compare ignores stored C=0
    step(1'b0, 8'h00, 8'h01);
    check("R3 setup borrow", 4'b1000);
    step(1'b0, 8'h05, 8'h03);
    check("R3 carry ignores stored C", 4'b0010);

    // R4: plain compare ignores stored Z=0
    step(1'b0, 8'h07, 8'h07);
    check("R4 zero ignores stored Z", 4'b0110);

    // R7: borrow consumed by compare-with-carry
    step(1'b0, 8'h00, 8'h01);
    step(1'b1, 8'h05, 8'h05);
    check("R7 borrow subtracted", 4'b1000);
    step(1'b0, 8'h03, 8'h03);
    step(1'b1, 8'h09, 8'h04);
    check("R7 no borrow", 4'b0010);

    // R8: equal word does not set a cleared Z
    step(1'b0, 8'h05, 8'h03);
    step(1'b1, 8'h04, 8'h04);
    check("R8 Z stays clear", 4'b0010);

    // R6: overflow in a single word
    step(1'b0, 8'h80, 8'h01);
    check("R6 single word overflow", 4'b0011);

    // R2: idle with changing inputs
    step(1'b0, 8'h10, 8'h10);
    en = 1'b0; op_carry = 1'b1; opa = 8'h00; opb = 8'hFF;
    repeat (3) @(negedge clk);
    check("R2 hold while idle", 4'b0110);
    // R2: idle gap inside a chain keeps the chain intact
    step(1'b0, 8'h00, 8'hFF);
    op_carry = 1'b0; opa = 8'h55; opb = 8'h22;
    repeat (2) @(negedge clk);
    step(1'b1, 8'h01, 8'h00);
    check("R2 R9 gap in chain", 4'b0010);

    // R1: reset wins over enable
    step(1'b0, 8'hFF, 8'h00);
    rst = 1'b1; en = 1'b1; op_carry = 1'b0; opa = 8'h80; opb = 8'h01;
    @(negedge clk);
    rst = 1'b0; en = 1'b0;
    check("R1 reset with enable", 4'b0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule